// File: doc/BRIEF.md
# Processor Startup Mode Sequencer

This block sits beside a small 16-bit processor core and decides how the core comes out of reset. After reset is released it holds a bus-init pulse for a fixed number of cycles. It then samples a 2-bit startup-mode input and settles on the first program counter and the initial processor status word (PS). Finally it raises a one-cycle start strobe that tells the core to begin fetching at that PC with that PS.

The behaviour depends on an elaboration parameter that selects one of four core flavours:

- **Discrete-logic core.** The PS always starts cleared and the PC comes from the console start address.
- **Basic single-chip core.** It has four startup modes.
- **Extended single-chip core.** It also defines mode 3 as an entry into a custom PROM.
- **Console-less core.** It always enters the boot ROM.

For the power-recovery mode, the block fetches the saved PC and PS from fixed low memory locations. It does this over a simple request/acknowledge word-read port.

Whenever the block enters a boot routine, it forces priority level 7. This keeps a clock interrupt that cannot be disabled from being taken before its vectors exist. Once the core has started, the block also gates interrupt requests. It reports the highest pending level and accepts that level only when it lies strictly above the PS priority field. The core may rewrite the PS through a write strobe, which is how software later lowers the priority.

Top module: `startup_seq`

## Requirements
- R1: `bus_init` is high throughout reset and for exactly 8 clock edges after reset is released (low after the 8th). While it is high, neither `mem_rd_req` nor `core_start` is asserted.
- R2: With the discrete-logic flavour (KIND 0), startup ends with `core_ps` = 0 and `core_pc` = `start_pc`, whatever the mode is. No memory read is made.
- R3: On a single-chip flavour (KIND 1 or 2), mode 0 (power recovery) works as follows:
  - It reads octal 024 and then octal 026. Each read completes on a clock edge where `mem_rd_req` and `mem_rd_ack` are both high.
  - `core_pc` is loaded with the first word and `core_ps` with the second.
  - `core_start` rises in the cycle after the second read completes.
- R4: On a single-chip flavour, mode 1 (go) gives `core_ps` = 0 and `core_pc` = `start_pc`.
- R5: On a single-chip flavour, mode 2 (boot) gives `core_ps` = octal 340 and `core_pc` = `BOOT_ADDR` (default octal 173000). PS bits 7:5 then read 111, which is priority 7.
- R6: Mode 3 depends on the single-chip flavour:
  - Basic flavour (KIND 1): it behaves as mode 1.
  - Extended flavour (KIND 2): it gives `core_ps` = octal 340 and `core_pc` = `PROM_ADDR` (default octal 165000).
- R7: The console-less flavour (KIND 3) always gives `core_ps` = octal 340 and `core_pc` = `BOOT_ADDR`, whatever the mode is.
- R8: `core_start` is a single-cycle pulse, issued once per reset. For entries without a memory read, it is high in the 9th cycle after reset release.
- R9: How interrupt requests are gated:
  - `irq_req[n]` requests level n (n = 1..7).
  - `irq_level` shows the highest level requested, or 0 if none is.
  - `irq_accept` is high only after `core_start`, and only when that level is strictly greater than `core_ps[7:5]`.
- R10: After start, a clock edge with `core_ps_we` high loads `core_ps_wdata` into `core_ps`. Without the strobe, `core_ps` keeps its value.
- R11: While `mem_rd_req` is high and `mem_rd_ack` is low, the request and `mem_rd_addr` hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Startup mode, sampled when bus-init ends |
| start_pc | input | 16 | Console start address used by go entries |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_ack | input | 1 | Read completes on an edge where req and ack are high |
| mem_rd_data | input | 16 | Read data, valid with ack |
| bus_init | output | 1 | Peripheral bus initialisation pulse |
| core_start | output | 1 | One-cycle start strobe to the core |
| core_pc | output | 16 | First program counter |
| core_ps | output | 16 | Current processor status word |
| core_ps_we | input | 1 | PS write strobe from the core |
| core_ps_wdata | input | 16 | PS write data |
| irq_req | input | 7 (7:1) | Interrupt request per level |
| irq_accept | output | 1 | Highest pending request is accepted |
| irq_level | output | 3 | Highest pending level |

## Verification
The bench runs all four flavours side by side, with every mode, a random start address and random saved words. Read acknowledges arrive with random latency, so a design that latched the PS from the wrong read, or started before the second word came back, shows a wrong PS or an early start. A level-6 clock request is applied right after every entry. A boot entry that left the priority at 0 would accept it, and a design that compared with "greater or equal" would accept level 7 against priority 7. Requests held high through reset catch any accept before start. A bus-init pulse of 7 or 9 cycles moves the start cycle away from the ninth.

// File: rtl/startup_pkg.sv
// Package: shared types and the startup entry decision for the startup sequencer.
// Assumes a 16-bit word and a priority field in PS bits 7:5.
package startup_pkg;

    typedef logic [15:0] word_t;

    // Core flavour chosen at elaboration.
    typedef enum logic [1:0] {
        KIND_DISCRETE   = 2'd0,
        KIND_SC_BASIC   = 2'd1,
        KIND_SC_EXT     = 2'd2,
        KIND_NO_CONSOLE = 2'd3
    } core_kind_e;

    // Startup modes on the mode input.
    typedef enum logic [1:0] {
        MODE_RESTORE = 2'd0,
        MODE_GO      = 2'd1,
        MODE_BOOT    = 2'd2,
        MODE_PROM    = 2'd3
    } start_mode_e;

    typedef enum logic [1:0] {
        SEQ_INIT  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        FET_IDLE = 2'd0,
        FET_PC   = 2'd1,
        FET_PS   = 2'd2
    } fetch_state_e;

    localparam int PRIO_LO = 5;
    localparam int PRIO_HI = 7;
    localparam word_t PS_MASKED = 16'o000340;
    localparam word_t PS_CLEAR  = 16'o000000;

    typedef struct packed {
        logic  restore;
        word_t pc;
        word_t ps;
    } entry_t;

    // Decide the entry path for one flavour and mode.
    function automatic entry_t pick_entry(core_kind_e kind, logic [1:0] mode,
                                          word_t go_pc, word_t boot_pc, word_t prom_pc);
        entry_t e;
        e.restore = 1'b0;
        e.pc      = go_pc;
        e.ps      = PS_CLEAR;
        case (kind)
            KIND_DISCRETE: begin
                e.pc = go_pc;
                e.ps = PS_CLEAR;
            end
            KIND_NO_CONSOLE: begin
                e.pc = boot_pc;
                e.ps = PS_MASKED;
            end
            default: begin
                case (start_mode_e'(mode))
                    MODE_RESTORE: e.restore = 1'b1;
                    MODE_GO: begin
                        e.pc = go_pc;
                        e.ps = PS_CLEAR;
                    end
                    MODE_BOOT: begin
                        e.pc = boot_pc;
                        e.ps = PS_MASKED;
                    end
                    default: begin
                        if (kind == KIND_SC_EXT) begin
                            e.pc = prom_pc;
                            e.ps = PS_MASKED;
                        end else begin
                            e.pc = go_pc;
                            e.ps = PS_CLEAR;
                        end
                    end
                endcase
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sus_init_timer.sv
// Module: sus_init_timer
// Holds bus_init high during reset and for CYCLES edges after release,
// then raises init_done for good. Assumes CYCLES >= 1.
module sus_init_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic bus_init,
    output logic init_done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count edges since reset release, saturating at CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Pulse is active until the count saturates.
    always_comb begin
        init_done = (cnt_q == LAST);
        bus_init  = !init_done;
    end

endmodule

// File: rtl/sus_fetch.sv
// Module: sus_fetch
// Reads the saved PC and then the saved PS over a request/acknowledge port.
// A read completes on an edge where req and ack are both high; data is valid with ack.
// done pulses combinationally on the completing edge of the second read.
module sus_fetch #(
    parameter startup_pkg::word_t PC_ADDR = 16'o000024,
    parameter startup_pkg::word_t PS_ADDR = 16'o000026
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    output logic               mem_rd_req,
    output startup_pkg::word_t mem_rd_addr,
    input  logic               mem_rd_ack,
    input  startup_pkg::word_t mem_rd_data,
    output logic               done,
    output startup_pkg::word_t pc_word,
    output startup_pkg::word_t ps_word
);
    import startup_pkg::*;

    fetch_state_e state_q;
    word_t        pc_q;

    // Step through the two reads and keep the first word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FET_IDLE;
            pc_q    <= '0;
        end else begin
            case (state_q)
                FET_IDLE: if (go) state_q <= FET_PC;
                FET_PC: if (mem_rd_ack) begin
                    pc_q    <= mem_rd_data;
                    state_q <= FET_PS;
                end
                FET_PS: if (mem_rd_ack) state_q <= FET_IDLE;
                default: state_q <= FET_IDLE;
            endcase
        end
    end

    // Port drive and completion.
    always_comb begin
        mem_rd_req  = (state_q != FET_IDLE);
        mem_rd_addr = (state_q == FET_PS) ? PS_ADDR : PC_ADDR;
        done        = (state_q == FET_PS) && mem_rd_ack;
        pc_word     = pc_q;
        ps_word     = mem_rd_data;
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

endmodule

// File: rtl/sus_irq_gate.sv
// Module: sus_irq_gate
// Finds the highest requested level and accepts it when enabled and above the priority.
// Assumes request bit n stands for level n, levels 1..7.
module sus_irq_gate #(
    parameter int LVL_W = 3
) (
    input  logic                  enable,
    input  logic [LVL_W-1:0]      prio,
    input  logic [(1<<LVL_W)-1:1] irq_req,
    output logic                  irq_accept,
    output logic [LVL_W-1:0]      irq_level
);
    localparam int TOP = (1 << LVL_W) - 1;

    // Priority encode, then compare strictly above the current priority.
    always_comb begin
        irq_level = '0;
        for (int n = 1; n <= TOP; n++) begin
            if (irq_req[n]) irq_level = LVL_W'(n);
        end
        irq_accept = enable && (irq_level != '0) && (irq_level > prio);
    end

endmodule

// File: rtl/startup_seq.sv
// Module: startup_seq (top)
// Sequences core startup: bus-init pulse, mode sampling, optional saved-word
// fetch, PC/PS selection per flavour, start strobe, then interrupt gating.
// Assumes mode and start_pc are steady when bus_init ends.
module startup_seq #(
    parameter startup_pkg::core_kind_e KIND = startup_pkg::KIND_SC_EXT,
    parameter startup_pkg::word_t BOOT_ADDR = 16'o173000,
    parameter startup_pkg::word_t PROM_ADDR = 16'o165000,
    parameter startup_pkg::word_t SAVED_PC_ADDR = 16'o000024,
    parameter startup_pkg::word_t SAVED_PS_ADDR = 16'o000026,
    parameter int INIT_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode,
    input  logic [15:0] start_pc,
    output logic        mem_rd_req,
    output logic [15:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [15:0] mem_rd_data,
    output logic        bus_init,
    output logic        core_start,
    output logic [15:0] core_pc,
    output logic [15:0] core_ps,
    input  logic        core_ps_we,
    input  logic [15:0] core_ps_wdata,
    input  logic [7:1]  irq_req,
    output logic        irq_accept,
    output logic [2:0]  irq_level
);
    import startup_pkg::*;

    seq_state_e state_q;
    entry_t     plan;
    logic       init_done;
    logic       fetch_go;
    logic       fetch_done;
    word_t      fetch_pc;
    word_t      fetch_ps;

    sus_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_init (bus_init),
        .init_done(init_done)
    );

    sus_fetch #(.PC_ADDR(SAVED_PC_ADDR), .PS_ADDR(SAVED_PS_ADDR)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fetch_go),
        .mem_rd_req (mem_rd_req),
        .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack (mem_rd_ack),
        .mem_rd_data(mem_rd_data),
        .done       (fetch_done),
        .pc_word    (fetch_pc),
        .ps_word    (fetch_ps)
    );

    sus_irq_gate #(.LVL_W(3)) u_gate (
        .enable    (state_q == SEQ_RUN),
        .prio      (core_ps[PRIO_HI:PRIO_LO]),
        .irq_req   (irq_req),
        .irq_accept(irq_accept),
        .irq_level (irq_level)
    );

    // Entry decision for the sampled mode.
    always_comb begin
        plan     = pick_entry(KIND, mode, start_pc, BOOT_ADDR, PROM_ADDR);
        fetch_go = (state_q == SEQ_INIT) && init_done && plan.restore;
    end

    // Startup state, PC/PS registers and start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_INIT;
            core_pc    <= '0;
            core_ps    <= '0;
            core_start <= 1'b0;
        end else begin
            core_start <= 1'b0;
            case (state_q)
                SEQ_INIT: if (init_done) begin
                    if (plan.restore) begin
                        state_q <= SEQ_FETCH;
                    end else begin
                        core_pc    <= plan.pc;
                        core_ps    <= plan.ps;
                        core_start <= 1'b1;
                        state_q    <= SEQ_RUN;
                    end
                end
                SEQ_FETCH: if (fetch_done) begin
                    core_pc    <= fetch_pc;
                    core_ps    <= fetch_ps;
                    core_start <= 1'b1;
                    state_q    <= SEQ_RUN;
                end
                SEQ_RUN: if (core_ps_we) core_ps <= core_ps_wdata;
                default: state_q <= SEQ_INIT;
            endcase
        end
    end

    assert_start_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !bus_init);

    assert_no_read_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !bus_init);

    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    assert_noconsole_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && KIND == KIND_NO_CONSOLE) |-> (core_ps[PRIO_HI:PRIO_LO] == 3'd7));

    assert_ps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && !core_ps_we) |=> $stable(core_ps));

endmodule

// File: tb/startup_seq_bench.sv
`timescale 1ns/1ps
module startup_seq_bench;
    localparam logic [15:0] BOOT = 16'o173000;
    localparam logic [15:0] PROM = 16'o165000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] start_pc = 16'h0;
    logic [15:0] saved_pc = 16'h0;
    logic [15:0] saved_ps = 16'h0;
    logic        ps_we = 1'b0;
    logic [15:0] ps_wdata = 16'h0;
    logic [7:1]  irq = 7'h0;

    logic        req_w  [4];
    logic [15:0] addr_w [4];
    logic        ack_r  [4];
    logic [15:0] data_w [4];
    logic        init_w [4];
    logic        start_w[4];
    logic [15:0] pc_w   [4];
    logic [15:0] ps_w   [4];
    logic        acc_w  [4];
    logic [2:0]  lvl_w  [4];

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : gen_dut
        assign data_w[g] = (addr_w[g] == 16'o24) ? saved_pc :
                           (addr_w[g] == 16'o26) ? saved_ps : 16'hDEAD;
        startup_seq #(.KIND(startup_pkg::core_kind_e'(g))) u_startup_seq (
            .clk(clk), .rst_n(rst_n), .mode(mode), .start_pc(start_pc),
            .mem_rd_req(req_w[g]), .mem_rd_addr(addr_w[g]),
            .mem_rd_ack(ack_r[g]), .mem_rd_data(data_w[g]),
            .bus_init(init_w[g]), .core_start(start_w[g]),
            .core_pc(pc_w[g]), .core_ps(ps_w[g]),
            .core_ps_we(ps_we), .core_ps_wdata(ps_wdata),
            .irq_req(irq), .irq_accept(acc_w[g]), .irq_level(lvl_w[g])
        );
    end

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(int kind, int m);
        if (kind == 0) return "R2";
        if (kind == 3) return "R7";
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic bit exp_restore(int kind, int m);
        return (kind == 1 || kind == 2) && m == 0;
    endfunction

    function automatic logic [15:0] exp_pc(int kind, int m);
        if (kind == 0) return start_pc;
        if (kind == 3) return BOOT;
        case (m)
            0: return saved_pc;
            1: return start_pc;
            2: return BOOT;
            default: return (kind == 2) ? PROM : start_pc;
        endcase
    endfunction

    function automatic logic [15:0] exp_ps(int kind, int m);
        if (kind == 0) return 16'o0;
        if (kind == 3) return 16'o340;
        case (m)
            0: return saved_ps;
            1: return 16'o0;
            2: return 16'o340;
            default: return (kind == 2) ? 16'o340 : 16'o0;
        endcase
    endfunction

    // Expected accept and level for a pattern against a PS (R9).
    task automatic check_irq(int i, logic [7:1] pat, logic [15:0] ps, string note);
        int hi = 0;
        for (int n = 1; n <= 7; n++) if (pat[n]) hi = n;
        check("R9", {note, " level"}, {29'd0, lvl_w[i]}, hi);
        check("R9", {note, " accept"}, {31'd0, acc_w[i]}, (hi != 0 && hi > int'(ps[7:5])) ? 1 : 0);
    endtask

    task automatic run_trial(int m, logic [15:0] spc, logic [15:0] spw, logic [15:0] sps);
        int st_cyc[4];
        int st_cnt[4];
        int hs_cnt[4];
        int hs_cyc[4];
        logic [15:0] hs_addr[4][2];
        bit early_acc[4];
        bit init_req[4];
        logic [15:0] cur_ps[4];
        @(negedge clk);
        rst_n = 1'b0; mode = 2'(m); start_pc = spc; saved_pc = spw; saved_ps = sps;
        irq = 7'h7F; ps_we = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ack_r[i] = 1'b0; st_cyc[i] = -1; st_cnt[i] = 0; hs_cnt[i] = 0; hs_cyc[i] = -1;
            early_acc[i] = 1'b0; init_req[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1", "bus_init in reset", {31'd0, init_w[2]}, 1);
        rst_n = 1'b1;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (k == 7) check("R1", "bus_init after 7 edges", {31'd0, init_w[i]}, 1);
                if (k == 8) check("R1", "bus_init after 8 edges", {31'd0, init_w[i]}, 0);
                if (init_w[i] && (req_w[i] || start_w[i])) init_req[i] = 1'b1;
                if (start_w[i]) begin
                    st_cnt[i]++;
                    if (st_cyc[i] < 0) st_cyc[i] = k;
                end
                if (st_cyc[i] < 0 && !start_w[i] && acc_w[i]) early_acc[i] = 1'b1;
                ack_r[i] = 1'($urandom_range(0, 1));
                if (req_w[i] && ack_r[i]) begin
                    if (hs_cnt[i] < 2) hs_addr[i][hs_cnt[i]] = addr_w[i];
                    hs_cnt[i]++;
                    hs_cyc[i] = k;
                end
            end
        end
        for (int i = 0; i < 4; i++) begin
            string t = tag_of(i, m);
            check("R1", "read or start during bus_init", {31'd0, init_req[i]}, 0);
            check("R8", "start count", st_cnt[i], 1);
            check(t, "core_pc", {16'd0, pc_w[i]}, {16'd0, exp_pc(i, m)});
            check(t, "core_ps", {16'd0, ps_w[i]}, {16'd0, exp_ps(i, m)});
            check("R9", "accept before start", {31'd0, early_acc[i]}, 0);
            if (exp_restore(i, m)) begin
                check("R3", "read count", hs_cnt[i], 2);
                check("R3", "first read addr", {16'd0, hs_addr[i][0]}, 32'o24);
                check("R3", "second read addr", {16'd0, hs_addr[i][1]}, 32'o26);
                check("R3", "start after second read", st_cyc[i], hs_cyc[i] + 1);
            end else begin
                check(t, "no memory read", hs_cnt[i], 0);
                check("R8", "start cycle", st_cyc[i], 9);
            end
            cur_ps[i] = ps_w[i];
        end
        // Clock interrupt at level 6 right after entry.
        irq = 7'b0100000;
        #1;
        for (int i = 0; i < 4; i++) begin
            check_irq(i, irq, cur_ps[i], "clock irq after entry");
            if (exp_ps(i, m) == 16'o340)
                check("R5", "masked clock irq", {31'd0, acc_w[i]}, 0);
        end
        // Several request patterns, including level 7 against priority 7.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            irq = (p == 0) ? 7'b1000000 : (p == 1) ? 7'b0000001 : 7'($urandom);
            #1;
            for (int i = 0; i < 4; i++) check_irq(i, irq, cur_ps[i], "pattern");
        end
        // Software lowers the priority (R10), then the clock request is taken.
        @(negedge clk);
        ps_we = 1'b1; ps_wdata = {8'($urandom), 3'($urandom_range(0, 5)), 5'($urandom)};
        irq = 7'b0100000;
        @(negedge clk);
        ps_we = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R10", "ps write", {16'd0, ps_w[i]}, {16'd0, ps_wdata});
            check_irq(i, irq, ps_wdata, "after ps write");
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            check("R10", "ps held", {16'd0, ps_w[i]}, {16'd0, ps_wdata});
    endtask

    initial begin
        void'($urandom(32'h5EED_0340));
        for (int i = 0; i < 4; i++) ack_r[i] = 1'b0;
        for (int m = 0; m < 4; m++) run_trial(m, 16'o001000, 16'o012345, 16'o000340);
        run_trial(0, 16'o000200, 16'o177776, 16'o000000);
        for (int r = 0; r < 14; r++)
            run_trial($urandom_range(0, 3), 16'($urandom) & 16'hFFFE,
                      16'($urandom), 16'($urandom));
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule